// File: doc/BRIEF.md
# Power-Fail Access Gate

This block stands between a parallel SRAM-style control interface and a memory core, and decides cycle by cycle whether an access may reach the core. It decodes two chip enables (one active low, one active high), an active-low output enable and an active-low write enable into read strobe, write strobe and output-drive signals. It also watches two digital comparator flags, one saying the supply is under the deselect threshold and one saying it is under the battery switchover threshold. Whenever the supply is not healthy it blocks every access.

A four-state sequencer tracks supply health. After the supply comes back, access stays blocked for a recovery interval counted on the reference clock: the parameter `REF_KHZ` (reference cycles per millisecond) times `RECOV_MS` (milliseconds, meant to lie between 40 and 200). When the interval has run out, access is released only at a clock edge where the chip is deselected. This way a write that was already set up on the bus can never land half-formed. The control and status pins are plain levels, because no data stream passes through this block.

Top module: `pf_access_gate`

## Requirements
- R1: `core_rd` is 1 exactly when the state is NORMAL, `below_deselect` is 0, `we_n`=1, `ce1_n`=0 and `ce2`=1, in the same cycle as those inputs.
- R2: `core_wr` is 1 exactly when the state is NORMAL, `below_deselect` is 0, `we_n`=0, `ce1_n`=0 and `ce2`=1. It falls in the same cycle as the first of these conditions to clear.
- R3: `drive_en` is 1 only while `core_rd` is 1 and `oe_n` is 0. A low `we_n` removes drive in the same cycle, and an access that selects the chip with `we_n` already low never drives.
- R4: While `below_deselect` is 1, `core_rd`, `core_wr` and `drive_en` are 0 in that same cycle, including when a write is in progress. The edge that follows moves the state to PROTECT, or to BATTERY if `below_switch` is also 1.
- R5: `below_switch`=1 at an edge moves the state to BATTERY. `batt_sel` is 1 exactly while the state is BATTERY. At the first edge with `below_switch`=0 the state leaves BATTERY: it goes to PROTECT if `below_deselect` is 1, and to RECOVER otherwise.
- R6: With both flags clear and the chip deselected, the state stays RECOVER for exactly `REF_KHZ*RECOV_MS` cycles and then becomes NORMAL.
- R7: If the chip is selected (`ce1_n`=0 and `ce2`=1) when the interval expires, the state stays RECOVER. It becomes NORMAL at the first edge where the chip is deselected.
- R8: `state_o` encodes NORMAL=0, PROTECT=1, BATTERY=2, RECOVER=3. Reset puts the state in PROTECT, and NORMAL is entered only from RECOVER.
- R9: In PROTECT, BATTERY and RECOVER, all chip-enable, output-enable and write-enable inputs are ignored: `core_rd`, `core_wr` and `drive_en` stay 0.
- R10: If either flag asserts during RECOVER, the state returns to PROTECT or BATTERY. The next recovery restarts its count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that paces the recovery timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| below_deselect | input | 1 | Supply is under the deselect threshold |
| below_switch | input | 1 | Supply is under the battery switchover threshold |
| core_rd | output | 1 | Read strobe to the memory core |
| core_wr | output | 1 | Write strobe to the memory core |
| drive_en | output | 1 | Enable for the data output drivers |
| batt_sel | output | 1 | Selects the battery as the supply source |
| state_o | output | 2 | Current sequencer state |

## Verification
The three access outputs are combinational in the pins and the registered state, so they are due in the cycle of the stimulus. The bench drives inputs on the falling edge and samples the outputs 1 ns later, before the next rising edge. `state_o` and `batt_sel` change one rising edge after the flag or select condition that causes them. The bench model therefore advances its expected state only after each sample, and the next sample compares against it. Recovery length is checked by counting cycles, with exact expected values at the `REF_KHZ*RECOV_MS` boundary and at one cycle before it.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PF_NORMAL  = 2'd0,
    PF_PROTECT = 2'd1,
    PF_BATTERY = 2'd2,
    PF_RECOVER = 2'd3
  } pf_state_e;
endpackage

// File: rtl/pfg_access_decode.sv
// Combinational access decode; every strobe is qualified by allow.
module pfg_access_decode (
  input  logic ce1_n,
  input  logic ce2,
  input  logic oe_n,
  input  logic we_n,
  input  logic allow,
  output logic selected,
  output logic rd,
  output logic wr,
  output logic drv
);
  always_comb begin
    selected = !ce1_n && ce2;
    rd  = allow && selected && we_n;
    wr  = allow && selected && !we_n;
    drv = rd && !oe_n;
  end
endmodule

// File: rtl/pfg_recov_timer.sv
// Holds at zero while idle, counts while run is high, saturates at LIMIT-1.
module pfg_recov_timer #(
  parameter int LIMIT = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/pfg_sequencer.sv
module pfg_sequencer
  import pfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      below_deselect,
  input  logic      below_switch,
  input  logic      deselected,
  input  logic      expired,
  output pf_state_e state
);
  pf_state_e nxt;

  always_comb begin
    nxt = state;
    if (below_switch)        nxt = PF_BATTERY;
    else if (below_deselect) nxt = PF_PROTECT;
    else begin
      unique case (state)
        PF_PROTECT, PF_BATTERY: nxt = PF_RECOVER;
        PF_RECOVER: if (expired && deselected) nxt = PF_NORMAL;
        default:    nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PF_PROTECT;
    else        state <= nxt;
  end
endmodule

// File: rtl/pf_access_gate.sv
module pf_access_gate
  import pfg_pkg::*;
#(
  parameter int REF_KHZ  = 32,
  parameter int RECOV_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       below_deselect,
  input  logic       below_switch,
  output logic       core_rd,
  output logic       core_wr,
  output logic       drive_en,
  output logic       batt_sel,
  output logic [1:0] state_o
);
  localparam int LIMIT = REF_KHZ * RECOV_MS;

  pf_state_e state;
  logic      selected, expired, allow;

  assign allow = (state == PF_NORMAL) && !below_deselect;

  pfg_access_decode u_dec (
    .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n), .allow(allow),
    .selected(selected), .rd(core_rd), .wr(core_wr), .drv(drive_en)
  );

  pfg_recov_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == PF_RECOVER), .expired(expired)
  );

  pfg_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .below_deselect(below_deselect), .below_switch(below_switch),
    .deselected(!selected), .expired(expired), .state(state)
  );

  assign batt_sel = (state == PF_BATTERY);
  assign state_o  = state;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int LIMIT = 3200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce1_n,
  input logic       ce2,
  input logic       oe_n,
  input logic       we_n,
  input logic       below_deselect,
  input logic       below_switch,
  input logic       core_rd,
  input logic       core_wr,
  input logic       drive_en,
  input logic       batt_sel,
  input logic [1:0] state_o
);
  logic [31:0] rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rec_len <= '0;
    else if (state_o == 2'd3) rec_len <= rec_len + 1;
    else                      rec_len <= '0;
  end

  // R4
  dsl_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_deselect |-> (!core_rd && !core_wr && !drive_en));

  // R9
  blocked_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |-> (!core_rd && !core_wr && !drive_en));

  // R3
  drive_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (core_rd && !oe_n && we_n && !ce1_n && ce2));

  // R5
  battery_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_switch |=> (batt_sel && state_o == 2'd2));

  // R6
  recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |=> (state_o != 2'd0 || rec_len >= LIMIT));

  // R7
  release_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !ce1_n && ce2) |=> (state_o != 2'd0));

  // R8
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && state_o != 2'd3) |=> (state_o != 2'd0));
endmodule

bind pf_access_gate pfg_checker #(.LIMIT(LIMIT)) u_pfg_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
  .below_deselect(below_deselect), .below_switch(below_switch),
  .core_rd(core_rd), .core_wr(core_wr), .drive_en(drive_en),
  .batt_sel(batt_sel), .state_o(state_o)
);

// File: tb/test_pf_access_gate.sv
module test_pf_access_gate;
  localparam int KHZ = 2;
  localparam int MS  = 40;
  localparam int LIM = KHZ * MS;
  localparam logic [1:0] S_NORM = 2'd0, S_PROT = 2'd1, S_BATT = 2'd2, S_RECV = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic below_deselect = 1'b1, below_switch = 1'b0;
  logic core_rd, core_wr, drive_en, batt_sel;
  logic [1:0] state_o;

  int checks = 0;
  int fails = 0;
  logic [1:0] m_state = S_PROT;
  int m_cnt = 0;

  always #4 clk = ~clk;

  pf_access_gate #(.REF_KHZ(KHZ), .RECOV_MS(MS)) i_pf_access_gate (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .below_deselect(below_deselect), .below_switch(below_switch),
    .core_rd(core_rd), .core_wr(core_wr), .drive_en(drive_en),
    .batt_sel(batt_sel), .state_o(state_o)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] next_state(input logic [1:0] s, input logic dsl,
                                            input logic sw, input logic desel, input int cnt);
    if (sw) return S_BATT;
    if (dsl) return S_PROT;
    if (s == S_PROT || s == S_BATT) return S_RECV;
    if (s == S_RECV && cnt == LIM - 1 && desel) return S_NORM;
    return s;
  endfunction

  task automatic step(input logic c1n, input logic c2, input logic oen, input logic wen,
                      input logic dsl, input logic sw, input string stag);
    logic ok, sel, e_rd, e_wr, e_drv;
    logic [1:0] ns;
    string t;
    @(negedge clk);
    ce1_n = c1n; ce2 = c2; oe_n = oen; we_n = wen;
    below_deselect = dsl; below_switch = sw;
    #1;
    sel   = !c1n && c2;
    ok    = (m_state == S_NORM) && !dsl;
    e_rd  = ok && sel && wen;
    e_wr  = ok && sel && !wen;
    e_drv = e_rd && !oen;
    t = dsl ? "R4" : ((m_state != S_NORM) ? "R9" : "");
    check({1'b0, core_rd},  {1'b0, e_rd},  (t == "") ? "R1" : t);
    check({1'b0, core_wr},  {1'b0, e_wr},  (t == "") ? "R2" : t);
    check({1'b0, drive_en}, {1'b0, e_drv}, (t == "") ? "R3" : t);
    check(state_o, m_state, stag);
    check({1'b0, batt_sel}, {1'b0, m_state == S_BATT}, "R5");
    ns = next_state(m_state, dsl, sw, !sel, m_cnt);
    if (m_state == S_RECV && ns == S_RECV) m_cnt = (m_cnt < LIM - 1) ? m_cnt + 1 : m_cnt;
    else m_cnt = 0;
    m_state = ns;
  endtask

  task automatic rand_access(input string stag);
    logic [3:0] r;
    r = 4'($urandom);
    step(r[0] & r[3], r[1] | r[3], r[2], ($urandom % 3) != 0, 1'b0, 1'b0, stag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state is PROTECT
    step(1, 0, 1, 1, 1, 0, "R8");
    step(1, 0, 1, 1, 0, 0, "R8");
    // R6: exact recovery length with chip deselected
    for (int i = 0; i < LIM; i++) step(1, 0, 1, 1, 0, 0, "R6");
    step(1, 0, 1, 1, 0, 0, "R6");
    // R1 R2 R3: random access patterns in NORMAL
    for (int i = 0; i < 400; i++) rand_access("R8");
    // R3: select with write already low, then write to read turnaround
    step(0, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    // R4: write in progress aborted by deselect flag
    step(0, 1, 1, 0, 0, 0, "R4");
    step(0, 1, 1, 0, 1, 0, "R4");
    step(0, 1, 1, 0, 1, 0, "R4");
    // R7: interval expires with chip still selected
    for (int i = 0; i < LIM + 6; i++) step(0, 1, 0, 1, 0, 0, "R7");
    step(1, 1, 0, 1, 0, 0, "R7");
    step(1, 1, 0, 1, 0, 0, "R7");
    // R5: switchover, then back through PROTECT
    step(1, 0, 1, 1, 1, 1, "R5");
    step(1, 0, 1, 1, 1, 1, "R5");
    step(1, 0, 1, 1, 1, 0, "R5");
    step(1, 0, 1, 1, 0, 0, "R5");
    // R10: flag pulse mid-recovery restarts the count
    for (int i = 0; i < LIM / 2; i++) step(1, 0, 1, 1, 0, 0, "R10");
    step(1, 0, 1, 1, 1, 0, "R10");
    for (int i = 0; i < LIM + 2; i++) step(1, 0, 1, 1, 0, 0, "R10");
    // mixed random flag bursts with random access
    for (int k = 0; k < 8; k++) begin
      int len;
      logic sw;
      len = 1 + int'($urandom % 5);
      sw  = ($urandom % 2) == 1;
      for (int i = 0; i < len; i++) step(1, 0, 1, 1, 1, sw, "R5");
      for (int i = 0; i < LIM + 40; i++) rand_access("R8");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule